// File: doc/BRIEF.md
# Single-Converter Receive Sample Deframer

This block sits on the receive path of a high-speed serial converter link, between the data link layer and a streaming sample consumer. Each 32-bit word from the link layer holds two 16-bit sample containers. The block cuts each word into its two containers and emits one 12-bit converter sample per frame clock, with the 4 tail bits of the container on a separate control output.

The design runs entirely in the frame-clock domain. The frame clock is twice the link clock and phase aligned with it, so every link word is held at the input for two frame cycles. A half-select counter runs while link-valid is high and picks the lower container first. The outputs are registered and follow the sampled input by one frame cycle. A parameter enables a mode that holds output valid low for the first four samples of each burst. These samples are the eight octets that an unseeded descrambler upstream can corrupt.

Top module: `jrx_deframer`

## Requirements
- R1: While `rst` is sampled high, the next clock edge drives `lnk_rdy`, `smp_vld`, `smp_data` and `smp_tail` to zero and selects the lower container.
- R2: `lnk_rdy` is high from the first clock edge that samples `rst` low, and stays high until the next reset.
- R3: Over consecutive cycles with `lnk_vld` high, the container taken alternates between `lnk_word[15:0]` and `lnk_word[31:16]`, starting with `[15:0]`. Any cycle with `lnk_vld` low makes the next valid cycle start again at `[15:0]`.
- R4: `smp_data` equals bits [15:4] of the selected container, so word 0xDDCCBBAA gives 0xBBA and then 0xDDC.
- R5: `smp_tail` equals bits [3:0] of the selected container, with bit 0 the container LSB, so word 0xDDCCBBAA gives 0xA and then 0xC.
- R6: Sample, tail and (when not suppressed) `smp_vld` appear at the clock edge that samples `lnk_vld` high and are visible in the cycle after it.
- R7: A clock edge that samples `lnk_vld` low drives `smp_vld` low and leaves `smp_data` and `smp_tail` unchanged.
- R8: With `SKIP_SEED=1`, the first four samples of every burst have `smp_vld` low, while data and tail still update. Valid goes high from the fifth sample. A burst shorter than five samples produces no valid sample.
- R9: With `SKIP_SEED=0`, every sample taken while `lnk_vld` is high, including the first of a burst, has `smp_vld` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst | input | 1 | Synchronous active-high frame reset |
| lnk_vld | input | 1 | Link word valid from the link layer |
| lnk_word | input | 32 | Link word, held for two frame cycles |
| lnk_rdy | output | 1 | Ready toward the link layer |
| smp_vld | output | 1 | Output sample valid |
| smp_data | output | 12 | Converter sample (container bits 15:4) |
| smp_tail | output | 4 | Container tail bits (container bits 3:0) |

## Verification
Each result is due one clock edge after the inputs that cause it. Sample, tail and valid follow the sampled `lnk_vld` and `lnk_word` by one edge. `lnk_rdy` rises at the first edge that samples reset low. The bench drives inputs on the falling edge and reads the outputs one nanosecond after the following rising edge. It checks against a model that updates exactly once per edge. The model tracks the half-select and the per-burst sample count, so the fifth-sample boundary of the seed-skip mode is checked at its exact cycle.

// File: rtl/jrx_pkg.sv
`timescale 1ns/1ps
package jrx_pkg;
  localparam int LINK_W_DEF  = 32;
  localparam int CONT_W_DEF  = 16;
  localparam int RES_W_DEF   = 12;
  localparam int SEED_OCTETS = 8;
  localparam int OCTET_W     = 8;
endpackage

// File: rtl/jrx_phase.sv
`timescale 1ns/1ps
module jrx_phase #(
  parameter int HALVES = 2,
  localparam int SEL_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [SEL_W-1:0] sel
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sel <= '0;
    end else if (sel == SEL_W'(HALVES - 1)) begin
      sel <= '0;
    end else begin
      sel <= sel + 1'b1;
    end
  end
endmodule

// File: rtl/jrx_seed_gate.sv
`timescale 1ns/1ps
module jrx_seed_gate #(
  parameter bit SKIP_EN = 1'b0,
  parameter int SKIP_N  = 4,
  localparam int CNT_W  = $clog2(SKIP_N + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic pass
);
  logic [CNT_W-1:0] taken;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      taken <= '0;
    end else if (taken < CNT_W'(SKIP_N)) begin
      taken <= taken + 1'b1;
    end
  end

  assign pass = run && (!SKIP_EN || (taken == CNT_W'(SKIP_N)));
endmodule

// File: rtl/jrx_deframer.sv
`timescale 1ns/1ps
module jrx_deframer #(
  parameter int LINK_W   = jrx_pkg::LINK_W_DEF,
  parameter int CONT_W   = jrx_pkg::CONT_W_DEF,
  parameter int RES_W    = jrx_pkg::RES_W_DEF,
  parameter bit SKIP_SEED = 1'b0,
  localparam int TAIL_W  = CONT_W - RES_W,
  localparam int HALVES  = LINK_W / CONT_W,
  localparam int SEL_W   = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int SKIP_N  = (jrx_pkg::SEED_OCTETS * jrx_pkg::OCTET_W) / CONT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lnk_vld,
  input  logic [LINK_W-1:0] lnk_word,
  output logic              lnk_rdy,
  output logic              smp_vld,
  output logic [RES_W-1:0]  smp_data,
  output logic [TAIL_W-1:0] smp_tail
);
  logic [SEL_W-1:0]  sel;
  logic              pass;
  logic [CONT_W-1:0] cont;
  logic [CONT_W-1:0] lanes [HALVES];

  jrx_phase #(.HALVES(HALVES)) u_phase (
    .clk(clk), .rst(rst), .run(lnk_vld), .sel(sel)
  );

  jrx_seed_gate #(.SKIP_EN(SKIP_SEED), .SKIP_N(SKIP_N)) u_gate (
    .clk(clk), .rst(rst), .run(lnk_vld), .pass(pass)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_lane
    assign lanes[h] = lnk_word[h*CONT_W +: CONT_W];
  end

  always_comb begin
    cont = lanes[0];
    for (int h = 1; h < HALVES; h++) begin
      if (sel == SEL_W'(h)) cont = lanes[h];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lnk_rdy  <= 1'b0;
      smp_vld  <= 1'b0;
      smp_data <= '0;
      smp_tail <= '0;
    end else begin
      lnk_rdy <= 1'b1;
      smp_vld <= pass;
      if (lnk_vld) begin
        smp_data <= cont[CONT_W-1:TAIL_W];
        smp_tail <= cont[TAIL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/jrx_deframer_chk.sv
`timescale 1ns/1ps
module jrx_deframer_chk #(
  parameter int LINK_W    = 32,
  parameter int CONT_W    = 16,
  parameter int RES_W     = 12,
  parameter bit SKIP_SEED = 1'b0,
  localparam int TAIL_W   = CONT_W - RES_W
) (
  input logic              clk,
  input logic              rst,
  input logic              lnk_vld,
  input logic [LINK_W-1:0] lnk_word,
  input logic              lnk_rdy,
  input logic              smp_vld,
  input logic [RES_W-1:0]  smp_data,
  input logic [TAIL_W-1:0] smp_tail
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: outputs cleared after a reset edge
  always @(negedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R1: assert (!lnk_rdy && !smp_vld && smp_data == '0 && smp_tail == '0)
        else $error("reset state not clear");
    end
  end

  assert_ready_up_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> lnk_rdy);

  assert_lower_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(lnk_vld) |=> ({smp_data, smp_tail} == $past(lnk_word[CONT_W-1:0])));

  assert_half_pick_R4: assert property (@(posedge clk) disable iff (rst)
    lnk_vld |=> (({smp_data, smp_tail} == $past(lnk_word[CONT_W-1:0])) ||
                 ({smp_data, smp_tail} == $past(lnk_word[LINK_W-1:LINK_W-CONT_W]))));

  assert_valid_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !lnk_vld |=> (!smp_vld && $stable(smp_data) && $stable(smp_tail)));

  if (SKIP_SEED) begin : g_skip
    assert_seed_hidden_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(lnk_vld) |=> !smp_vld);
  end else begin : g_noskip
    assert_first_valid_R9: assert property (@(posedge clk) disable iff (rst)
      lnk_vld |=> smp_vld);
  end
endmodule

bind jrx_deframer jrx_deframer_chk #(
  .LINK_W(LINK_W), .CONT_W(CONT_W), .RES_W(RES_W), .SKIP_SEED(SKIP_SEED)
) u_chk (.*);

// File: tb/test_jrx_deframer.sv
`timescale 1ns/1ps
module test_jrx_deframer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lnk_vld = 1'b0;
  logic [31:0] lnk_word = '0;
  logic        rdy0, vld0, rdy1, vld1;
  logic [11:0] dat0, dat1;
  logic [3:0]  tl0, tl1;

  int checks = 0;
  int fails  = 0;

  // model state
  int          m_phase = 0;
  int          m_cnt = 0;
  logic [11:0] m_dat = '0;
  logic [3:0]  m_tl = '0;

  always #2.5 clk = ~clk;

  jrx_deframer #(.SKIP_SEED(1'b0)) i_jrx_deframer (
    .clk(clk), .rst(rst), .lnk_vld(lnk_vld), .lnk_word(lnk_word),
    .lnk_rdy(rdy0), .smp_vld(vld0), .smp_data(dat0), .smp_tail(tl0)
  );

  jrx_deframer #(.SKIP_SEED(1'b1)) i_jrx_deframer_skip (
    .clk(clk), .rst(rst), .lnk_vld(lnk_vld), .lnk_word(lnk_word),
    .lnk_rdy(rdy1), .smp_vld(vld1), .smp_data(dat1), .smp_tail(tl1)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [31:0] w);
    logic [15:0] cont;
    logic        ev0, ev1, erdy;
    @(negedge clk);
    rst = r; lnk_vld = v; lnk_word = w;
    if (r) begin
      m_phase = 0; m_cnt = 0; m_dat = '0; m_tl = '0;
      ev0 = 1'b0; ev1 = 1'b0; erdy = 1'b0;
    end else if (v) begin
      cont  = (m_phase == 1) ? w[31:16] : w[15:0];
      m_dat = cont[15:4];
      m_tl  = cont[3:0];
      ev0   = 1'b1;
      ev1   = (m_cnt == 4);
      if (m_cnt < 4) m_cnt++;
      m_phase = 1 - m_phase;
      erdy = 1'b1;
    end else begin
      m_phase = 0; m_cnt = 0;
      ev0 = 1'b0; ev1 = 1'b0; erdy = 1'b1;
    end
    @(posedge clk);
    #1;
    if (r) begin
      chk("R1 ready", rdy0, 0);
      chk("R1 valid", vld0, 0);
      chk("R1 data", dat0, 0);
      chk("R1 tail", tl0, 0);
      chk("R1 skip valid", vld1, 0);
    end else begin
      chk("R2 ready", rdy0, erdy);
      chk("R2 ready skip", rdy1, erdy);
      chk(v ? "R3 R4 R6 data" : "R7 data hold", dat0, m_dat);
      chk(v ? "R3 R5 R6 tail" : "R7 tail hold", tl0, m_tl);
      chk(v ? "R9 R6 valid" : "R7 valid low", vld0, ev0);
      chk("R8 skip valid", vld1, ev1);
      chk("R8 skip data", dat1, m_dat);
      chk("R8 skip tail", tl1, m_tl);
    end
  endtask

  task automatic burst(input int words, input int base);
    for (int k = 0; k < words; k++) begin
      logic [31:0] w;
      w = 32'h9E3779B9 * (base + k) + 32'h0F1E2D3C;
      step(1'b0, 1'b1, w);
      step(1'b0, 1'b1, w);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 32'h0);
    // R2 ready on first edge after release
    step(1'b0, 1'b0, 32'h0);
    step(1'b0, 1'b0, 32'h0);
    // R4 R5 worked example: 0xDDCCBBAA -> 0xBBA/0xA then 0xDDC/0xC
    step(1'b0, 1'b1, 32'hDDCCBBAA);
    chk("R4 example low", dat0, 12'hBBA);
    chk("R5 example low", tl0, 4'hA);
    step(1'b0, 1'b1, 32'hDDCCBBAA);
    chk("R4 example high", dat0, 12'hDDC);
    chk("R5 example high", tl0, 4'hC);
    step(1'b0, 1'b0, 32'h0);
    // R8 boundary sweep: bursts of 1..8 words, idle gaps
    for (int n = 1; n <= 8; n++) begin
      burst(n, n * 16);
      step(1'b0, 1'b0, 32'h12345678);
      if (n % 2 == 0) step(1'b0, 1'b0, 32'h0);
    end
    // R3 restart: odd number of valid frame cycles, then resume at lower half
    for (int n = 1; n <= 7; n += 2) begin
      for (int k = 0; k < n; k++) step(1'b0, 1'b1, 32'hA5C3_0000 + 32'(k * 4369 + n));
      step(1'b0, 1'b0, 32'h0);
      step(1'b0, 1'b1, 32'h4433_2211 + 32'(n));
      step(1'b0, 1'b1, 32'h4433_2211 + 32'(n));
      step(1'b0, 1'b0, 32'h0);
    end
    // long burst, then reset in the middle of valid data (R1)
    burst(6, 500);
    step(1'b1, 1'b1, 32'hFFFF_FFFF);
    step(1'b0, 1'b0, 32'h0);
    burst(3, 900);
    step(1'b0, 1'b0, 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule